// File: doc/BRIEF.md
# Capture and Interrupt Status Unit

This unit sits next to a free-running up/down counter. For each of up to `NCH` input channels it watches the channel pin. When the channel is enabled, any change of level, rising or falling, copies the counter value into that channel's capture register and raises that channel's flag. The unit also keeps a flag for the counter's update (wrap) event, an interrupt-enable mask laid out like the flags, and one registered interrupt line. The counter and its clock divider are outside the unit.

Software reaches the unit through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational. A flag is cleared by writing 0 to its bit, and writing 1 leaves it as it is. Software can therefore write all ones apart from the bits it wants to drop. Only the channels marked in `IMPL_MASK` exist. Writing ones to every channel-enable bit and reading back shows which channels are fitted.

Top module: `capture_irq_unit`

## Requirements
- R1: After reset, the flag, interrupt-enable, channel-enable and capture registers all read 0 and `irq_o` is low.
- R2: If an enabled channel's input differs from its value in the previous cycle, on either a rising or a falling change, that channel's capture register takes the `cnt_i` value of that cycle. The new value is readable from the next cycle.
- R3: A capture on channel k sets flag bit k+1 of the flag register (address 0).
- R4: A write to address 0 clears each flag whose write-data bit is 0. Write-data bits that are 1 leave their flags unchanged and never set a flag.
- R5: An `upd_evt_i` pulse sets flag bit 0.
- R6: If a flag is set and cleared by software in the same cycle, the flag ends up set.
- R7: The interrupt-enable register (address 1) has the same bit layout as the flags. `irq_o` is high in the cycle after (flags AND enables) is nonzero, and low in the cycle after it is zero.
- R8: The channel-enable register (address 2) keeps only the bits set in `IMPL_MASK`. Bit k enables channel k, and bits of channels that are not fitted read 0.
- R9: A disabled channel makes no capture and sets no flag, and its capture register keeps its last value.
- R10: Capture register k is read at address 3+k. Reads of any other unmapped address return 0, and captures are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CW | Counter value to capture |
| chan_i | input | NCH | Channel inputs, one per channel |
| upd_evt_i | input | 1 | Counter update (wrap) event pulse |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A wrong edge register or a faulty enable gate shows up as a capture register or flag differing from the model one cycle after the pin change. A faulty write mask shows up in the cycle after the write. The bench reads every address after every clock, so a bad flag, mask or capture value is reported in the cycle it first appears. A wrong interrupt term shows up on `irq_o` exactly one cycle after the flag or enable change that should have moved it.

// File: rtl/capture_irq_pkg.sv
package capture_irq_pkg;
  localparam int unsigned ADDR_FLAGS = 0;
  localparam int unsigned ADDR_IEN   = 1;
  localparam int unsigned ADDR_CHEN  = 2;
  localparam int unsigned ADDR_CAP0  = 3;
endpackage

// File: rtl/capture_irq_chan.sv
module capture_irq_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pin_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] cap_o,
  output logic          hit_o
);
  logic prev_q;

  // prev tracks the pin even while disabled, so enabling never fakes an edge
  assign hit_o = en_i && (pin_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cap_o  <= '0;
    end else begin
      prev_q <= pin_i;
      if (hit_o) cap_o <= cnt_i;
    end
  end
endmodule

// File: rtl/capture_irq_flags.sv
module capture_irq_flags #(
  parameter int unsigned SW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [SW-1:0] keep_i,
  input  logic          ien_we_i,
  input  logic [SW-1:0] ien_wd_i,
  output logic [SW-1:0] flags_o,
  output logic [SW-1:0] ien_o,
  output logic          irq_o
);
  logic [SW-1:0] kept;

  assign kept = clr_we_i ? (flags_o & keep_i) : flags_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      ien_o   <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= kept | set_i;  // a new event beats a same-cycle clear
      if (ien_we_i) ien_o <= ien_wd_i;
      irq_o <= |(flags_o & ien_o);
    end
  end
endmodule

// File: rtl/capture_irq_unit.sv
module capture_irq_unit
  import capture_irq_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned CW        = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned AW        = 3,
  parameter logic [NCH-1:0] IMPL_MASK = 4'b0111
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [NCH-1:0] chan_i,
  input  logic          upd_evt_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int unsigned SW = NCH + 1;

  logic [NCH-1:0]         chen_q;
  logic [NCH-1:0]         hit_w;
  logic [NCH-1:0][CW-1:0] cap_w;
  logic [SW-1:0]          flags_w;
  logic [SW-1:0]          ien_w;
  logic                   wr_flags, wr_ien, wr_chen;

  assign wr_flags = we_i && (int'(addr_i) == ADDR_FLAGS);
  assign wr_ien   = we_i && (int'(addr_i) == ADDR_IEN);
  assign wr_chen  = we_i && (int'(addr_i) == ADDR_CHEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chen_q <= '0;
    else if (wr_chen) chen_q <= wdata_i[NCH-1:0] & IMPL_MASK;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    capture_irq_chan #(.CW(CW)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (chen_q[k]),
      .pin_i (chan_i[k]),
      .cnt_i (cnt_i),
      .cap_o (cap_w[k]),
      .hit_o (hit_w[k])
    );
  end

  capture_irq_flags #(.SW(SW)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({hit_w, upd_evt_i}),
    .clr_we_i(wr_flags),
    .keep_i  (wdata_i[SW-1:0]),
    .ien_we_i(wr_ien),
    .ien_wd_i(wdata_i[SW-1:0]),
    .flags_o (flags_w),
    .ien_o   (ien_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    int idx;
    rdata_o = '0;
    idx     = int'(addr_i) - int'(ADDR_CAP0);
    if (int'(addr_i) == ADDR_FLAGS)     rdata_o[SW-1:0]  = flags_w;
    else if (int'(addr_i) == ADDR_IEN)  rdata_o[SW-1:0]  = ien_w;
    else if (int'(addr_i) == ADDR_CHEN) rdata_o[NCH-1:0] = chen_q;
    else if (idx >= 0 && idx < int'(NCH)) rdata_o[CW-1:0] = cap_w[idx];
  end
endmodule

// File: rtl/capture_irq_unit_chk.sv
module capture_irq_unit_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned DW  = 16,
  parameter int unsigned AW  = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [CW-1:0]          cnt_i,
  input logic                   upd_evt_i,
  input logic                   we_i,
  input logic [AW-1:0]          addr_i,
  input logic [DW-1:0]          wdata_i,
  input logic                   irq_o,
  input logic [NCH-1:0]         chen_q,
  input logic [NCH-1:0]         hit_w,
  input logic [NCH-1:0][CW-1:0] cap_w,
  input logic [NCH:0]           flags_w,
  input logic [NCH:0]           ien_w
);
  for (genvar k = 0; k < NCH; k++) begin : g_chk
    p_capture_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_w[k] |=> cap_w[k] == $past(cnt_i));
    p_capture_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_w[k] |=> flags_w[k+1]);
    p_disabled_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chen_q[k] |=> $stable(cap_w[k]));
  end

  p_no_spurious_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_evt_i && hit_w == '0) |=> (flags_w & ~$past(flags_w)) == '0);
  p_set_beats_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == '0 && !wdata_i[0] && upd_evt_i) |=> flags_w[0]);
  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_w & ien_w)) |=> irq_o);
  p_irq_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flags_w & ien_w)) |=> !irq_o);
endmodule

bind capture_irq_unit capture_irq_unit_chk #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_i),
  .upd_evt_i(upd_evt_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .chen_q   (chen_q),
  .hit_w    (hit_w),
  .cap_w    (cap_w),
  .flags_w  (flags_w),
  .ien_w    (ien_w)
);

// File: tb/capture_irq_unit_tb.sv
module capture_irq_unit_tb;
  localparam int HALF = 4000;  // ps, 125 MHz
  localparam int NCH  = 4;
  localparam logic [3:0] IMPL = 4'b0111;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cnt_i = '0;
  logic [3:0]  chan_i = '0;
  logic        upd_evt_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  int m_flags, m_ien, m_chen, m_prev, m_irq;
  int m_cap [NCH];

  capture_irq_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt_i), .chan_i(chan_i),
    .upd_evt_i(upd_evt_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(HALF) clk_i = ~clk_i;

  function automatic int exp_rd(int a);
    if (a == 0) return m_flags;
    if (a == 1) return m_ien;
    if (a == 2) return m_chen;
    if (a >= 3 && a < 3 + NCH) return m_cap[a-3];
    return 0;
  endfunction

  function automatic string tag_of(int a);
    if (a == 0) return "R3 R4 R5 R6";
    if (a == 1) return "R7";
    if (a == 2) return "R8";
    if (a >= 3 && a < 3 + NCH) return "R2 R9";
    return "R10";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sweep(string force_tag);
    we_i = 1'b0;
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a);
      #100;
      check(force_tag == "" ? tag_of(a) : force_tag, int'(rdata_o), exp_rd(a));
    end
    check(force_tag == "" ? "R7 irq" : force_tag, int'(irq_o), m_irq);
  endtask

  // one clock: drive at negedge, model the edge, compare after it
  task automatic cyc(logic we, int a, int wd, logic [3:0] ch, logic up);
    int set, nf;
    @(negedge clk_i);
    we_i = we; addr_i = 3'(a); wdata_i = 16'(wd); chan_i = ch; upd_evt_i = up;
    cnt_i = cnt_i + 16'd7;
    set = up ? 1 : 0;
    for (int k = 0; k < NCH; k++)
      if (((m_chen >> k) & 1) == 1 && int'(ch[k]) != ((m_prev >> k) & 1)) begin
        set |= 1 << (k + 1);
        m_cap[k] = int'(cnt_i);
      end
    m_irq = ((m_flags & m_ien) != 0) ? 1 : 0;
    nf = m_flags;
    if (we && a == 0) nf = nf & wd & 31;
    m_flags = nf | set;
    if (we && a == 1) m_ien = wd & 31;
    if (we && a == 2) m_chen = wd & int'(IMPL);
    m_prev = int'(ch);
    @(posedge clk_i);
    #500;
    sweep("");
  endtask

  initial begin
    #(64'd1600000000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_flags = 0; m_ien = 0; m_chen = 0; m_prev = 0; m_irq = 0;
    for (int k = 0; k < NCH; k++) m_cap[k] = 0;
    repeat (3) @(posedge clk_i);
    #500;
    sweep("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R8: probe fitted channels
    cyc(1, 2, 16'hffff, 4'b0000, 0);
    // R2 R3: rising then falling on ch0, then ch1, then ch0+ch2 together
    cyc(0, 0, 0, 4'b0001, 0);
    cyc(0, 0, 0, 4'b0000, 0);
    cyc(0, 0, 0, 4'b0010, 0);
    cyc(0, 0, 0, 4'b0111, 0);
    // unfitted ch3 toggles: nothing happens
    cyc(0, 0, 0, 4'b1111, 0);
    // R5 update event
    cyc(0, 0, 0, 4'b1111, 1);
    // R4: writing ones changes nothing, then clear bit 0 only
    cyc(1, 0, 16'hffff, 4'b1111, 0);
    cyc(1, 0, 16'hfffe, 4'b1111, 0);
    // R7: enable update irq, nothing pending yet
    cyc(1, 1, 16'h0001, 4'b1111, 0);
    cyc(0, 0, 0, 4'b1111, 1);
    cyc(0, 0, 0, 4'b1111, 0);
    // R6: clear bit0 and bit1 while both events arrive
    cyc(1, 0, 16'hfffc, 4'b1110, 1);
    cyc(0, 0, 0, 4'b1110, 0);
    // clear all, irq drops
    cyc(1, 0, 16'h0000, 4'b1110, 0);
    cyc(0, 0, 0, 4'b1110, 0);
    // R9: disable ch1, toggle it
    cyc(1, 2, 16'h0005, 4'b1110, 0);
    cyc(0, 0, 0, 4'b1100, 0);
    cyc(0, 0, 0, 4'b1110, 0);
    // capture irq on ch2
    cyc(1, 1, 16'h0008, 4'b1110, 0);
    cyc(0, 0, 0, 4'b1010, 0);
    cyc(0, 0, 0, 4'b1010, 0);
    // R10: write to capture address has no effect
    cyc(1, 5, 16'h1234, 4'b1010, 0);
    cyc(1, 7, 16'hffff, 4'b1010, 0);
    // re-enable ch1 while its pin is steady: no fake edge
    cyc(1, 2, 16'h0007, 4'b1010, 0);
    cyc(0, 0, 0, 4'b1010, 0);
    cyc(0, 0, 0, 4'b1000, 0);
    cyc(1, 0, 16'h0000, 4'b1000, 0);
    cyc(0, 0, 0, 4'b1000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule